// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This block sits between a 32-bit integer pipeline and a 32-bit data memory port. For each load or store it forms the effective address from a base register value plus a sign-extended 16-bit displacement. It checks that the access is naturally aligned to its size. For an aligned access it issues the memory request.

For stores it produces a 4-bit byte-enable. It also copies the byte or halfword of the source register across every lane, so the enabled lanes carry the right bits. For loads it keeps the access size, the extension mode and the byte offset in one register stage. When the data word returns, it uses them to pick out the addressed bytes and widen them to 32 bits, ready to be written to the destination register.

A misaligned access raises an address-error flag and reports the faulting address. It sends nothing to memory and never produces a register write. Byte lanes are little-endian: lane k holds the byte whose address has k in its two low bits.

Top module: `lsu_align`

## Requirements
- R1: The memory address equals `baseVal` plus `dispImm` sign-extended to 32 bits, computed modulo 2^32.
- R2: For an aligned store, `memByteEn` has bit k set for each byte the access covers, where k is the address's two low bits. A byte sets one bit at k. A halfword sets bits k and k+1. A word sets all four bits.
- R3: Store write data is the low byte of `storeData` repeated in all four lanes for a byte store. It is the low halfword repeated in both halves for a halfword store. It is `storeData` unchanged for a word store.
- R4: A signed byte or halfword load (op 0 = signed byte, op 2 = signed halfword) returns the addressed bytes of `memRdata` sign-extended to 32 bits.
- R5: An unsigned byte or halfword load (op 1 = unsigned byte, op 3 = unsigned halfword) returns the addressed bytes zero-extended to 32 bits.
- R6: A word load (op 4) returns `memRdata` unchanged. Store ops are 5 = byte, 6 = halfword and 7 = word.
- R7: A halfword at an odd address, or a word whose two low address bits are not 00, raises `addrErr` and drives `badAddr` to the effective address. In that cycle `memReqValid` is 0 and `memByteEn` is 0. Otherwise `addrErr` is 0.
- R8: The load result uses the size, extension mode and offset captured when the load was issued, even if a different request is presented in the cycle its data returns.
- R9: `loadWe` is 1 only in the cycle when `memRvalid` returns data for an issued, aligned load. A response after a store or after a misaligned load gives no write, and `loadWe` is 0 out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Pipeline presents an access this cycle |
| reqOp | input | 3 | Access kind, encoded as listed in R4 to R6 |
| baseVal | input | 32 | Base register value |
| dispImm | input | 16 | Signed displacement |
| storeData | input | 32 | Source register value for stores |
| memReqValid | output | 1 | Memory request issued |
| memWrite | output | 1 | Request is a store |
| memAddr | output | 32 | Effective byte address |
| memByteEn | output | 4 | Byte-lane enables |
| memWdata | output | 32 | Lane-positioned write data |
| memRvalid | input | 1 | Load data returned this cycle |
| memRdata | input | 32 | Returned data word |
| loadResult | output | 32 | Extended load value |
| loadWe | output | 1 | Write `loadResult` to the destination register |
| addrErr | output | 1 | Misaligned access detected |
| badAddr | output | 32 | Faulting address, zero when no error |

## Verification
The bench goes after sign versus zero extension when the top bit of the picked byte or halfword is set. A design that mixed them up would return the wrong upper 24 or 16 bits. It also tries every byte offset for byte stores and both halves for halfword stores, which would expose a lane map that is reversed or off by one. It issues a store in the same cycle a load's data returns, which catches a design that extracts data with the new request's offset instead of the captured one. Finally, it sends data responses after stores and after misaligned loads, so a design that lets a faulting access through, or writes the register on any response, shows a spurious write.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  localparam int unsigned LSU_DATA_W = 32;
  localparam int unsigned LSU_LANES  = LSU_DATA_W / 8;
  localparam int unsigned LSU_OFF_W  = $clog2(LSU_LANES);

  typedef enum logic [2:0] {
    OP_LB  = 3'd0,
    OP_LBU = 3'd1,
    OP_LH  = 3'd2,
    OP_LHU = 3'd3,
    OP_LW  = 3'd4,
    OP_SB  = 3'd5,
    OP_SH  = 3'd6,
    OP_SW  = 3'd7
  } memOp_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } accSize_e;

  // strobes from control to datapath
  typedef struct packed {
    accSize_e             reqSize;
    accSize_e             rspSize;
    logic                 rspSigned;
    logic [LSU_OFF_W-1:0] rspOffset;
  } alignStrb_t;
endpackage

// File: rtl/lsu_align_ctrl.sv
module lsu_align_ctrl
  import lsu_align_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [2:0]           reqOp,
  input  logic [LSU_OFF_W-1:0] addrLow,
  input  logic                 memRvalid,
  output alignStrb_t           strb,
  output logic                 reqGo,
  output logic                 reqIsStore,
  output logic                 misalign,
  output logic                 loadWe
);
  memOp_e   opDec;
  accSize_e curSize;
  logic     curSigned;
  logic     sizeBad;

  logic                 pendQ;
  accSize_e             rspSizeQ;
  logic                 rspSignedQ;
  logic [LSU_OFF_W-1:0] rspOffQ;

  always_comb begin
    opDec      = memOp_e'(reqOp);
    curSigned  = 1'b0;
    reqIsStore = 1'b0;
    curSize    = SZ_WORD;
    unique case (opDec)
      OP_LB:  begin curSize = SZ_BYTE; curSigned = 1'b1; end
      OP_LBU: curSize = SZ_BYTE;
      OP_LH:  begin curSize = SZ_HALF; curSigned = 1'b1; end
      OP_LHU: curSize = SZ_HALF;
      OP_LW:  curSize = SZ_WORD;
      OP_SB:  begin curSize = SZ_BYTE; reqIsStore = 1'b1; end
      OP_SH:  begin curSize = SZ_HALF; reqIsStore = 1'b1; end
      OP_SW:  begin curSize = SZ_WORD; reqIsStore = 1'b1; end
      default: curSize = SZ_WORD;
    endcase
  end

  always_comb begin
    unique case (curSize)
      SZ_HALF: sizeBad = addrLow[0];
      SZ_WORD: sizeBad = (addrLow != '0);
      default: sizeBad = 1'b0;
    endcase
  end

  assign misalign = reqValid & sizeBad;
  assign reqGo    = reqValid & ~sizeBad;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ      <= 1'b0;
      rspSizeQ   <= SZ_WORD;
      rspSignedQ <= 1'b0;
      rspOffQ    <= '0;
    end else if (reqGo && !reqIsStore) begin
      pendQ      <= 1'b1;
      rspSizeQ   <= curSize;
      rspSignedQ <= curSigned;
      rspOffQ    <= addrLow;
    end else if (memRvalid) begin
      pendQ <= 1'b0;
    end
  end

  assign loadWe         = memRvalid & pendQ;
  assign strb.reqSize   = curSize;
  assign strb.rspSize   = rspSizeQ;
  assign strb.rspSigned = rspSignedQ;
  assign strb.rspOffset = rspOffQ;

  // R9: a store issued with no load outstanding cannot lead to a write next cycle
  p_store_no_we_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqGo && reqIsStore && !pendQ) |=> !loadWe);
endmodule

// File: rtl/lsu_align_dp.sv
module lsu_align_dp
  import lsu_align_pkg::*;
#(
  parameter int unsigned IMM_W = 16
) (
  input  logic [LSU_DATA_W-1:0] baseVal,
  input  logic [IMM_W-1:0]      dispImm,
  input  logic [LSU_DATA_W-1:0] storeData,
  input  logic [LSU_DATA_W-1:0] memRdata,
  input  alignStrb_t            strb,
  input  logic                  reqGo,
  output logic [LSU_DATA_W-1:0] effAddr,
  output logic [LSU_LANES-1:0]  memByteEn,
  output logic [LSU_DATA_W-1:0] memWdata,
  output logic [LSU_DATA_W-1:0] loadResult
);
  localparam int unsigned HALF_W = LSU_DATA_W / 2;

  logic [LSU_OFF_W-1:0]  addrLow;
  logic [LSU_DATA_W-1:0] shifted;

  assign effAddr = baseVal + {{(LSU_DATA_W-IMM_W){dispImm[IMM_W-1]}}, dispImm};
  assign addrLow = effAddr[LSU_OFF_W-1:0];

  for (genvar g = 0; g < LSU_LANES; g++) begin : g_lane
    localparam logic [LSU_OFF_W-1:0] LANE_IDX = LSU_OFF_W'(g);
    logic hit;
    always_comb begin
      unique case (strb.reqSize)
        SZ_BYTE: hit = (addrLow == LANE_IDX);
        SZ_HALF: hit = (addrLow[LSU_OFF_W-1:1] == LANE_IDX[LSU_OFF_W-1:1]);
        default: hit = 1'b1;
      endcase
    end
    assign memByteEn[g] = reqGo & hit;
  end

  always_comb begin
    unique case (strb.reqSize)
      SZ_BYTE: memWdata = {LSU_LANES{storeData[7:0]}};
      SZ_HALF: memWdata = {(LSU_LANES/2){storeData[HALF_W-1:0]}};
      default: memWdata = storeData;
    endcase
  end

  assign shifted = memRdata >> {strb.rspOffset, 3'b000};

  always_comb begin
    unique case (strb.rspSize)
      SZ_BYTE: loadResult = {{(LSU_DATA_W-8){strb.rspSigned & shifted[7]}}, shifted[7:0]};
      SZ_HALF: loadResult = {{(LSU_DATA_W-HALF_W){strb.rspSigned & shifted[HALF_W-1]}},
                             shifted[HALF_W-1:0]};
      default: loadResult = memRdata;
    endcase
  end
endmodule

// File: rtl/lsu_align.sv
module lsu_align
  import lsu_align_pkg::*;
#(
  parameter int unsigned IMM_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [2:0]            reqOp,
  input  logic [LSU_DATA_W-1:0] baseVal,
  input  logic [IMM_W-1:0]      dispImm,
  input  logic [LSU_DATA_W-1:0] storeData,
  output logic                  memReqValid,
  output logic                  memWrite,
  output logic [LSU_DATA_W-1:0] memAddr,
  output logic [LSU_LANES-1:0]  memByteEn,
  output logic [LSU_DATA_W-1:0] memWdata,
  input  logic                  memRvalid,
  input  logic [LSU_DATA_W-1:0] memRdata,
  output logic [LSU_DATA_W-1:0] loadResult,
  output logic                  loadWe,
  output logic                  addrErr,
  output logic [LSU_DATA_W-1:0] badAddr
);
  alignStrb_t            strb;
  logic                  reqGo;
  logic                  reqIsStore;
  logic                  misalign;
  logic [LSU_DATA_W-1:0] effAddr;

  lsu_align_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqOp      (reqOp),
    .addrLow    (effAddr[LSU_OFF_W-1:0]),
    .memRvalid  (memRvalid),
    .strb       (strb),
    .reqGo      (reqGo),
    .reqIsStore (reqIsStore),
    .misalign   (misalign),
    .loadWe     (loadWe)
  );

  lsu_align_dp #(.IMM_W(IMM_W)) i_dp (
    .baseVal    (baseVal),
    .dispImm    (dispImm),
    .storeData  (storeData),
    .memRdata   (memRdata),
    .strb       (strb),
    .reqGo      (reqGo),
    .effAddr    (effAddr),
    .memByteEn  (memByteEn),
    .memWdata   (memWdata),
    .loadResult (loadResult)
  );

  assign memReqValid = reqGo;
  assign memWrite    = reqGo & reqIsStore;
  assign memAddr     = effAddr;
  assign addrErr     = misalign;
  assign badAddr     = misalign ? effAddr : '0;

  // R7: a faulting access leaves the memory port quiet
  p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    addrErr |-> (!memReqValid && memByteEn == '0));

  // R2: an issued access enables one, two or all lanes
  p_lane_count_r2: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> ($countones(memByteEn) == 1 || $countones(memByteEn) == 2 ||
                     $countones(memByteEn) == LSU_LANES));

  // R2: word stores enable every lane
  p_word_full_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memWrite && reqOp == 3'd7) |-> (memByteEn == '1));

  // R4: signed byte results carry the sign bit upward
  p_sext_byte_r4: assert property (@(posedge clk) disable iff (!rstN)
    (loadWe && strb.rspSize == SZ_BYTE && strb.rspSigned) |->
      (loadResult[LSU_DATA_W-1:8] == {(LSU_DATA_W-8){loadResult[7]}}));

  // R5: unsigned byte results have clear upper bits
  p_zext_byte_r5: assert property (@(posedge clk) disable iff (!rstN)
    (loadWe && strb.rspSize == SZ_BYTE && !strb.rspSigned) |->
      (loadResult[LSU_DATA_W-1:8] == '0));
endmodule

// File: tb/test_lsu_align.sv
`timescale 1ns/1ps
module test_lsu_align;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqOp = 3'd0;
  logic [31:0] baseVal = '0;
  logic [15:0] dispImm = '0;
  logic [31:0] storeData = '0;
  logic        memReqValid, memWrite, loadWe, addrErr;
  logic [31:0] memAddr, memWdata, loadResult, badAddr;
  logic [3:0]  memByteEn;
  logic        memRvalid = 1'b0;
  logic [31:0] memRdata = '0;

  int nVec = 0;
  int nBad = 0;
  logic [31:0] expVal[$];
  string       expTag[$];

  always #5 clk = ~clk;

  lsu_align i_lsu_align (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .baseVal(baseVal), .dispImm(dispImm), .storeData(storeData),
    .memReqValid(memReqValid), .memWrite(memWrite), .memAddr(memAddr),
    .memByteEn(memByteEn), .memWdata(memWdata), .memRvalid(memRvalid),
    .memRdata(memRdata), .loadResult(loadResult), .loadWe(loadWe),
    .addrErr(addrErr), .badAddr(badAddr)
  );

  task automatic checkEq(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] effOf(input logic [31:0] b, input logic [15:0] d);
    return b + {{16{d[15]}}, d};
  endfunction

  function automatic logic misOf(input logic [2:0] op, input logic [1:0] off);
    if (op == 3'd2 || op == 3'd3 || op == 3'd6) return off[0];
    if (op == 3'd4 || op == 3'd7) return off != 2'b00;
    return 1'b0;
  endfunction

  function automatic logic [31:0] expLoad(input logic [2:0] op, input logic [1:0] off,
                                          input logic [31:0] rd);
    logic [31:0] sh;
    sh = rd >> (8 * off);
    case (op)
      3'd0:    return {{24{sh[7]}}, sh[7:0]};
      3'd1:    return {24'h0, sh[7:0]};
      3'd2:    return {{16{sh[15]}}, sh[15:0]};
      3'd3:    return {16'h0, sh[15:0]};
      default: return rd;
    endcase
  endfunction

  // driver: request cycle, then response cycle (optionally with a store overlapping)
  task automatic doLoad(input logic [2:0] op, input logic [31:0] base, input logic [15:0] disp,
                        input logic [31:0] rd, input bit overlap, input string req);
    logic [31:0] eff;
    logic mis;
    eff = effOf(base, disp);
    mis = misOf(op, eff[1:0]);
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; baseVal = base; dispImm = disp; memRvalid = 1'b0;
    #1;
    checkEq("R7", "addrErr", {31'h0, addrErr}, {31'h0, mis});
    checkEq("R7", "memReqValid", {31'h0, memReqValid}, {31'h0, ~mis});
    if (mis) begin
      checkEq("R7", "badAddr", badAddr, eff);
      checkEq("R7", "memByteEn", {28'h0, memByteEn}, 32'h0);
    end else begin
      checkEq("R1", "memAddr", memAddr, eff);
      expVal.push_back(expLoad(op, eff[1:0], rd));
      expTag.push_back(req);
    end
    @(negedge clk);
    if (overlap) begin
      reqValid = 1'b1; reqOp = 3'd5; baseVal = eff + 32'd1; dispImm = '0; storeData = 32'h5A;
    end else begin
      reqValid = 1'b0;
    end
    memRvalid = 1'b1; memRdata = rd;
    #1;
    checkEq(mis ? "R9" : req, "loadWe", {31'h0, loadWe}, {31'h0, ~mis});
    @(negedge clk);
    memRvalid = 1'b0; reqValid = 1'b0;
  endtask

  task automatic doStore(input logic [2:0] op, input logic [31:0] base, input logic [15:0] disp,
                         input logic [31:0] data, input bit stray);
    logic [31:0] eff;
    logic mis;
    logic [3:0] en;
    logic [31:0] wd;
    eff = effOf(base, disp);
    mis = misOf(op, eff[1:0]);
    case (op)
      3'd5:    begin en = 4'b0001 << eff[1:0]; wd = {4{data[7:0]}}; end
      3'd6:    begin en = 4'b0011 << eff[1:0]; wd = {2{data[15:0]}}; end
      default: begin en = 4'b1111; wd = data; end
    endcase
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; baseVal = base; dispImm = disp; storeData = data;
    #1;
    checkEq("R7", "addrErr", {31'h0, addrErr}, {31'h0, mis});
    if (mis) begin
      checkEq("R7", "memReqValid", {31'h0, memReqValid}, 32'h0);
      checkEq("R7", "memByteEn", {28'h0, memByteEn}, 32'h0);
      checkEq("R7", "badAddr", badAddr, eff);
    end else begin
      checkEq("R1", "memAddr", memAddr, eff);
      checkEq("R2", "memWrite", {31'h0, memWrite}, 32'h1);
      checkEq("R2", "memByteEn", {28'h0, memByteEn}, {28'h0, en});
      checkEq("R3", "memWdata", memWdata, wd);
      checkEq("R7", "badAddr", badAddr, 32'h0);
    end
    @(negedge clk);
    reqValid = 1'b0;
    if (stray) begin
      memRvalid = 1'b1; memRdata = 32'hFFFF_FFFF;
      #1;
      checkEq("R9", "loadWe after store", {31'h0, loadWe}, 32'h0);
      @(negedge clk);
      memRvalid = 1'b0;
    end
  endtask

  // monitor: compares every register write against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rstN && loadWe) begin
        if (expVal.size() == 0) begin
          nVec++; nBad++;
          $display("FAIL R9 unexpected write actual=%h expected=none", loadResult);
        end else begin
          logic [31:0] e;
          string t;
          e = expVal.pop_front();
          t = expTag.pop_front();
          checkEq(t, "loadResult", loadResult, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nVec++; nBad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    #1;
    checkEq("R9", "reset loadWe", {31'h0, loadWe}, 32'h0);
    checkEq("R9", "reset memReqValid", {31'h0, memReqValid}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    // R1: negative displacement, wrap
    doStore(3'd7, 32'h0000_1000, 16'hFFFC, 32'h1234_5678, 1'b0);
    doStore(3'd7, 32'hFFFF_FFF0, 16'h0010, 32'hCAFE_F00D, 1'b0);
    // R2 R3: every byte lane, both halves
    for (int k = 0; k < 4; k++) doStore(3'd5, 32'h0000_2000, 16'(k), 32'h0000_00A7 + k, 1'b0);
    doStore(3'd6, 32'h0000_2000, 16'h0000, 32'h0000_BEEF, 1'b0);
    doStore(3'd6, 32'h0000_2000, 16'h0002, 32'h0000_1357, 1'b0);
    // R9: response after a store
    doStore(3'd5, 32'h0000_3000, 16'h0001, 32'h0000_0011, 1'b1);
    // R4 R5 R6: loads
    doLoad(3'd0, 32'h0000_4000, 16'h0003, 32'h8011_2233, 1'b0, "R4");
    doLoad(3'd1, 32'h0000_4000, 16'h0003, 32'h8011_2233, 1'b0, "R5");
    doLoad(3'd0, 32'h0000_4000, 16'h0001, 32'h0000_7F00, 1'b0, "R4");
    doLoad(3'd2, 32'h0000_4000, 16'h0002, 32'h8001_1234, 1'b0, "R4");
    doLoad(3'd3, 32'h0000_4000, 16'h0000, 32'h1234_F00D, 1'b0, "R5");
    doLoad(3'd4, 32'h0000_4004, 16'hFFFC, 32'hDEAD_BEEF, 1'b0, "R6");
    // R8: new store in the response cycle
    doLoad(3'd2, 32'h0000_5000, 16'h0002, 32'hC001_0002, 1'b1, "R8");
    doLoad(3'd1, 32'h0000_5000, 16'h0002, 32'h00E5_0000, 1'b1, "R8");
    // R7 R9: misaligned accesses
    doLoad(3'd2, 32'h0000_6000, 16'h0001, 32'h1111_1111, 1'b0, "R7");
    doLoad(3'd4, 32'h0000_6000, 16'h0002, 32'h2222_2222, 1'b0, "R7");
    doLoad(3'd3, 32'h0000_6003, 16'h0000, 32'h3333_3333, 1'b0, "R7");
    doStore(3'd6, 32'h0000_6000, 16'h0003, 32'h0000_4444, 1'b1);
    doStore(3'd7, 32'h0000_6000, 16'h0001, 32'h5555_5555, 1'b0);

    repeat (3) @(negedge clk);
    if (expVal.size() != 0) begin
      nVec++; nBad++;
      $display("FAIL R9 missing writes actual=%0d expected=0", expVal.size());
    end
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule